// File: doc/BRIEF.md
# Compact-Mode Branch Target Generator

This block turns the offset field of a 16-bit compact-mode branch into an absolute target address. Each cycle it may accept one branch descriptor: a kind code, a raw offset field and the address of the branch instruction. The offset is read as a signed halfword count and added to the instruction address plus four. Conditional branches use a short offset and are taken only when the externally evaluated condition passes. Unconditional jumps use a longer offset.

Subroutine calls reach further by using two consecutive instructions. The first half carries the upper eleven bits of a 22-bit offset. The block adds that part to its own address plus four and keeps the result. The second half supplies the lower eleven bits and produces both the final target and a return-link address. A second half that has no first half waiting is reported as an error.

All results are registered and appear one cycle after the descriptor is accepted. The strobes are single-cycle pulses.

Top module: `cbt_gen`

## Requirements
- R1: After reset, take_o, link_valid_o and orphan_err_o are low and no call first half is held, so a second half accepted as the first descriptor raises orphan_err_o.
- R2: Kind 2'b00 is a conditional branch. Only offset bits [7:0] are used, as a signed value; bits [10:8] are ignored. The target is pc + 4 + 2*offset, and take_o is high only when cond_pass_i was high.
- R3: Kind 2'b01 is an unconditional branch with a signed 11-bit offset. It always raises take_o, with target pc + 4 + 2*offset.
- R4: Kind 2'b10 is the first half of a call. It raises none of take_o, link_valid_o or orphan_err_o, and it stores its offset as the upper eleven bits of the call offset.
- R5: Kind 2'b11 accepted while a first half is held raises take_o. The target is the first half's pc + 4 + 2*S, where S is the signed 22-bit value {first offset, second offset}.
- R6: On a completed call, link_valid_o is high and link_o equals the second half's pc + 2 with bit 0 set. link_valid_o is low for every other kind.
- R7: Kind 2'b11 accepted with no first half held raises orphan_err_o and does not raise take_o or link_valid_o.
- R8: Accepting a conditional or unconditional branch drops a held first half. Accepting a new first half replaces the held one.
- R9: Outputs change on the clock edge that accepts a descriptor. Strobes last one cycle. A cycle with br_valid_i low raises no strobe and leaves a held first half in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| br_valid_i | input | 1 | Descriptor present this cycle |
| br_kind_i | input | 2 | 00 conditional, 01 unconditional, 10 call first half, 11 call second half |
| br_off_i | input | HALF_W (11) | Raw offset field |
| pc_i | input | ADDR_W (32) | Address of the branch instruction |
| cond_pass_i | input | 1 | Condition result for a conditional branch |
| target_o | output | ADDR_W | Branch target, meaningful while take_o is high |
| take_o | output | 1 | Branch taken pulse |
| link_o | output | ADDR_W | Return link address for a completed call |
| link_valid_o | output | 1 | link_o is valid |
| orphan_err_o | output | 1 | Call second half arrived with no first half held |

## Verification
The assertions assume that pc_i is always halfword aligned and that br_valid_i is held low while reset is asserted. Under these conditions every taken target is even, and every strobe can be traced back to a descriptor accepted on the previous edge. The stimulus drives only even addresses, including zero and addresses near the top of the address space so that wrap-around is covered. It applies descriptors only after reset has been released and holds the valid input low between them.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
   typedef enum logic [1:0] {
      BK_COND    = 2'b00,
      BK_JUMP    = 2'b01,
      BK_CALL_HI = 2'b10,
      BK_CALL_LO = 2'b11
   } br_kind_e;
endpackage

// File: rtl/cbt_offset_ext.sv
module cbt_offset_ext #(
   parameter int IN_W  = 8,
   parameter int OUT_W = 32,
   parameter int SHIFT = 1
) (
   input  logic [IN_W-1:0]  raw_i,
   output logic [OUT_W-1:0] ext_o
);
   localparam int SIGN_W = OUT_W - IN_W - SHIFT;

   if (SIGN_W < 1) begin : g_bad_width
      $error("cbt_offset_ext: OUT_W too small for IN_W plus SHIFT");
   end

   if (SHIFT == 0) begin : g_noshift
      assign ext_o = {{SIGN_W{raw_i[IN_W-1]}}, raw_i};
   end else begin : g_shift
      assign ext_o = {{SIGN_W{raw_i[IN_W-1]}}, raw_i, {SHIFT{1'b0}}};
   end
endmodule

// File: rtl/cbt_call_hold.sv
module cbt_call_hold #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_i,
   input  logic              clear_i,
   input  logic [ADDR_W-1:0] base_i,
   output logic              pending_o,
   output logic [ADDR_W-1:0] base_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_o <= 1'b0;
         base_o    <= '0;
      end else if (arm_i) begin
         pending_o <= 1'b1;
         base_o    <= base_i;
      end else if (clear_i) begin
         pending_o <= 1'b0;
      end
   end
endmodule

// File: rtl/cbt_gen.sv
module cbt_gen #(
   parameter int ADDR_W     = 32,
   parameter int COND_W     = 8,
   parameter int JUMP_W     = 11,
   parameter int HALF_W     = 11,
   parameter int INSN_BYTES = 2,
   parameter int PC_AHEAD   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              br_valid_i,
   input  logic [1:0]        br_kind_i,
   input  logic [HALF_W-1:0] br_off_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic              cond_pass_i,
   output logic [ADDR_W-1:0] target_o,
   output logic              take_o,
   output logic [ADDR_W-1:0] link_o,
   output logic              link_valid_o,
   output logic              orphan_err_o
);
   import cbt_pkg::*;

   localparam int HI_SHIFT = HALF_W + 1;
   localparam int LO_PAD   = ADDR_W - HALF_W - 1;

   if (COND_W > HALF_W || JUMP_W > HALF_W) begin : g_chk_field
      $error("cbt_gen: offset widths must fit the HALF_W field");
   end
   if (ADDR_W < 2 * HALF_W + 2) begin : g_chk_addr
      $error("cbt_gen: ADDR_W too narrow for the joined call offset");
   end

   br_kind_e          kind;
   logic [ADDR_W-1:0] pc_ahead, cond_ext, jump_ext, hi_ext, lo_ext;
   logic [ADDR_W-1:0] held_base;
   logic              held;
   logic              arm_hi, clear_hi;
   logic [ADDR_W-1:0] tgt_d, link_d;
   logic              take_d, lv_d, err_d, upd_tgt;

   assign kind     = br_kind_e'(br_kind_i);
   assign pc_ahead = pc_i + ADDR_W'(PC_AHEAD);
   assign lo_ext   = {{LO_PAD{1'b0}}, br_off_i, 1'b0};

   cbt_offset_ext #(.IN_W(COND_W), .OUT_W(ADDR_W), .SHIFT(1)) u_cond_ext (
      .raw_i(br_off_i[COND_W-1:0]), .ext_o(cond_ext));
   cbt_offset_ext #(.IN_W(JUMP_W), .OUT_W(ADDR_W), .SHIFT(1)) u_jump_ext (
      .raw_i(br_off_i[JUMP_W-1:0]), .ext_o(jump_ext));
   cbt_offset_ext #(.IN_W(HALF_W), .OUT_W(ADDR_W), .SHIFT(HI_SHIFT)) u_hi_ext (
      .raw_i(br_off_i), .ext_o(hi_ext));

   assign arm_hi   = br_valid_i && (kind == BK_CALL_HI);
   assign clear_hi = br_valid_i && (kind != BK_CALL_HI);

   cbt_call_hold #(.ADDR_W(ADDR_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .arm_i(arm_hi), .clear_i(clear_hi),
      .base_i(pc_ahead + hi_ext), .pending_o(held), .base_o(held_base));

   always_comb begin
      take_d  = 1'b0;
      lv_d    = 1'b0;
      err_d   = 1'b0;
      upd_tgt = 1'b0;
      tgt_d   = target_o;
      link_d  = pc_i + ADDR_W'(INSN_BYTES);
      link_d[0] = 1'b1;
      if (br_valid_i) begin
         unique case (kind)
            BK_COND: begin
               upd_tgt = 1'b1;
               tgt_d   = pc_ahead + cond_ext;
               take_d  = cond_pass_i;
            end
            BK_JUMP: begin
               upd_tgt = 1'b1;
               tgt_d   = pc_ahead + jump_ext;
               take_d  = 1'b1;
            end
            BK_CALL_HI: ;
            BK_CALL_LO: begin
               if (held) begin
                  upd_tgt = 1'b1;
                  tgt_d   = held_base + lo_ext;
                  take_d  = 1'b1;
                  lv_d    = 1'b1;
               end else begin
                  err_d   = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         target_o     <= '0;
         link_o       <= '0;
         take_o       <= 1'b0;
         link_valid_o <= 1'b0;
         orphan_err_o <= 1'b0;
      end else begin
         take_o       <= take_d;
         link_valid_o <= lv_d;
         orphan_err_o <= err_d;
         if (upd_tgt) target_o <= tgt_d;
         if (lv_d)    link_o   <= link_d;
      end
   end
endmodule

// File: rtl/cbt_gen_chk.sv
module cbt_gen_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              br_valid_i,
   input logic [1:0]        br_kind_i,
   input logic [ADDR_W-1:0] target_o,
   input logic              take_o,
   input logic [ADDR_W-1:0] link_o,
   input logic              link_valid_o,
   input logic              orphan_err_o
);
   a_r9_take_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> $past(br_valid_i));
   a_r4_first_half_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid_i && br_kind_i == 2'b10) |=> (!take_o && !link_valid_o && !orphan_err_o));
   a_r6_link_odd: assert property (@(posedge clk) disable iff (!rst_n)
      link_valid_o |-> (link_o[0] && take_o));
   a_r5_target_even: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> !target_o[0]);
   a_r7_orphan_source: assert property (@(posedge clk) disable iff (!rst_n)
      orphan_err_o |-> ($past(br_valid_i) && $past(br_kind_i) == 2'b11 && !take_o));
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !br_valid_i |=> (!take_o && !link_valid_o && !orphan_err_o));
endmodule

bind cbt_gen cbt_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .br_valid_i(br_valid_i), .br_kind_i(br_kind_i),
   .target_o(target_o), .take_o(take_o), .link_o(link_o),
   .link_valid_o(link_valid_o), .orphan_err_o(orphan_err_o));

// File: tb/cbt_gen_tb.sv
module cbt_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        br_valid_i = 1'b0;
   logic [1:0]  br_kind_i = 2'b00;
   logic [10:0] br_off_i = '0;
   logic [31:0] pc_i = '0;
   logic        cond_pass_i = 1'b0;
   logic [31:0] target_o, link_o;
   logic        take_o, link_valid_o, orphan_err_o;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   cbt_gen u_dut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [1:0] k, input logic [10:0] off,
                        input logic [31:0] pc, input logic pass);
      br_valid_i = v; br_kind_i = k; br_off_i = off; pc_i = pc; cond_pass_i = pass;
      @(negedge clk);
      br_valid_i = 1'b0;
   endtask

   function automatic logic [31:0] exp_cond(logic [31:0] pc, logic [7:0] o);
      return pc + 32'd4 + {{23{o[7]}}, o, 1'b0};
   endfunction
   function automatic logic [31:0] exp_jump(logic [31:0] pc, logic [10:0] o);
      return pc + 32'd4 + {{20{o[10]}}, o, 1'b0};
   endfunction
   function automatic logic [31:0] exp_call(logic [31:0] pc, logic [10:0] h, logic [10:0] l);
      return pc + 32'd4 + {{9{h[10]}}, h, l, 1'b0};
   endfunction

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] p1, p2;
      logic [10:0] lo;
      repeat (3) @(negedge clk);
      chk("R1 take", {31'd0, take_o}, 32'd0);
      chk("R1 link_valid", {31'd0, link_valid_o}, 32'd0);
      chk("R1 err", {31'd0, orphan_err_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      drive(1, 2'b11, 11'h123, 32'h100, 0);
      chk("R1 orphan after reset", {31'd0, orphan_err_o}, 32'd1);
      chk("R7 orphan no take", {30'd0, take_o, link_valid_o}, 32'd0);

      // R2 conditional sweep, both condition values, junk in upper bits
      for (int o = 0; o < 256; o++) begin
         for (int ps = 0; ps < 2; ps++) begin
            p1 = (o[0]) ? 32'h0000_0000 : 32'hFFFF_FF80;
            drive(1, 2'b00, {3'b101 ^ o[2:0], o[7:0]}, p1, ps[0]);
            chk("R2 take", {31'd0, take_o}, {31'd0, ps[0]});
            if (ps[0]) chk("R2 target", target_o, exp_cond(p1, o[7:0]));
         end
      end

      // R3 unconditional sweep
      for (int o = 0; o < 2048; o++) begin
         p1 = 32'h0004_0000 + {o[9:0], 1'b0};
         drive(1, 2'b01, o[10:0], p1, 0);
         chk("R3 take", {31'd0, take_o}, 32'd1);
         chk("R3 target", target_o, exp_jump(p1, o[10:0]));
      end

      // R4/R5/R6 call pairs over every first-half value
      for (int h = 0; h < 2048; h++) begin
         p1 = 32'h0080_0000 + {h[10:0], 2'b10};
         p2 = p1 + 32'd2;
         lo = h[10:0] ^ 11'h5A5;
         drive(1, 2'b10, h[10:0], p1, 1);
         chk("R4 strobes", {29'd0, take_o, link_valid_o, orphan_err_o}, 32'd0);
         drive(1, 2'b11, lo, p2, 0);
         chk("R5 take", {31'd0, take_o}, 32'd1);
         chk("R5 target", target_o, exp_call(p1, h[10:0], lo));
         chk("R6 link", link_o, p2 + 32'd3);
         chk("R6 link_valid", {30'd0, link_valid_o, orphan_err_o}, 32'd2);
      end

      // R8 interleaved branch drops held half
      drive(1, 2'b10, 11'h011, 32'h200, 0);
      drive(1, 2'b01, 11'h004, 32'h202, 0);
      chk("R6 no link on jump", {31'd0, link_valid_o}, 32'd0);
      drive(1, 2'b11, 11'h022, 32'h204, 0);
      chk("R8 dropped after jump", {30'd0, orphan_err_o, take_o}, 32'd2);
      drive(1, 2'b10, 11'h011, 32'h300, 0);
      drive(1, 2'b00, 11'h004, 32'h302, 0);
      drive(1, 2'b11, 11'h022, 32'h304, 0);
      chk("R8 dropped after cond", {31'd0, orphan_err_o}, 32'd1);

      // R8 second first half replaces the first
      drive(1, 2'b10, 11'h7FF, 32'h400, 0);
      drive(1, 2'b10, 11'h003, 32'h500, 0);
      drive(1, 2'b11, 11'h010, 32'h502, 0);
      chk("R8 replaced target", target_o, exp_call(32'h500, 11'h003, 11'h010));

      // R9 idle cycles keep the held half and raise nothing
      drive(1, 2'b10, 11'h400, 32'h8000_0000, 0);
      drive(0, 2'b11, 11'h001, 32'h0, 1);
      chk("R9 idle quiet", {29'd0, take_o, link_valid_o, orphan_err_o}, 32'd0);
      drive(0, 2'b01, 11'h001, 32'h0, 1);
      drive(1, 2'b11, 11'h001, 32'h8000_0002, 0);
      chk("R9 held across idle", target_o, exp_call(32'h8000_0000, 11'h400, 11'h001));
      @(negedge clk);
      chk("R9 one-cycle strobe", {30'd0, take_o, link_valid_o}, 32'd0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule